// File: doc/BRIEF.md
# Integer Condition Code and Overflow Trap Unit

This unit produces the four-bit integer condition code for an execution pipeline. The datapath does the arithmetic itself and hands this unit both source operands and the result. It also passes the operation class, the operand size and the processor status byte. The unit works out negative, zero, overflow and carry for add, subtract and compare. For move and test it derives negative and zero from the result, clears overflow and keeps the incoming carry. The code is available combinationally in the same cycle.

Beside the flag logic sits an 8-bit trap and interrupt request register. Its upper three bits hold a pending arithmetic trap code and its lower five bits hold the pending interrupt level. On a strobed flag update, a signed overflow with overflow trapping enabled posts trap code 1. Other units can post any trap code through a separate input, and a clear command empties the trap field. None of these actions touches the interrupt level, which changes only through its own write strobe.

Top module: `ccode_unit`

## Requirements
- R1: The code on `cc` is packed as N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. `size` selects the width: 0 is byte (sign in bit 7), 1 is word (bit 15), 2 is longword (bit 31) and 3 is quad. Operand and result bits above the selected width have no effect on the code.
- R2: Z is set only when the result is zero at the selected width, and Z is never set together with N.
- R3: For add (`op` = 0), V is set when the signed sum of the two operands does not fit in the width. C is set when the unsigned sum carries out, which shows as the result being unsigned-less-than `src2`.
- R4: For subtract (`op` = 1), the result is `src2` − `src1`. V is set when the signed difference does not fit in the width. C is set as a borrow when `src2` is unsigned-less-than `src1`.
- R5: For compare (`op` = 2), N is set when `src1` is signed-less-than `src2` and Z is set when the two are equal. V is 0, and C is set when `src1` is unsigned-less-than `src2`.
- R6: For move/test (`op` = 3), N and Z come from the result, V is 0 and C equals `old_c`.
- R7: For a quad move/test (`size` = 3), N is bit 31 of `res_hi` and Z requires both `res_lo` and `res_hi` to be zero. For add, subtract and compare, `size` = 3 is treated as longword.
- R8: When `upd` is high, V is set and `psw[5]` is 1, the next clock edge writes trap code 1 into `tir[7:5]`. When `psw[5]` is 0 or V is clear, the update posts nothing.
- R9: `tir[4:0]` changes only on a clock edge with `lvl_we` high, and it then takes `lvl_in`. Trap posts and clears leave it unchanged.
- R10: A clock edge with `clr_traps` high zeros `tir[7:5]`. In the same cycle, an overflow post outranks an external post, and an external post outranks a clear.
- R11: A clock edge with `post_trap` high writes `trap_code`, any value from 1 to 7, into `tir[7:5]`.
- R12: While `rst_n` is low, `tir` is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op | input | 2 | 0 add, 1 subtract, 2 compare, 3 move/test |
| size | input | 2 | 0 byte, 1 word, 2 longword, 3 quad |
| src1 | input | 32 | First operand |
| src2 | input | 32 | Second operand |
| res_lo | input | 32 | Result, low longword |
| res_hi | input | 32 | Result, high longword (quad move/test only) |
| old_c | input | 1 | Carry before the operation |
| psw | input | 8 | Processor status byte; bit 5 enables overflow trapping |
| upd | input | 1 | Flag update strobe |
| clr_traps | input | 1 | Clear the trap field |
| post_trap | input | 1 | Post `trap_code` into the trap field |
| trap_code | input | 3 | Trap code to post |
| lvl_we | input | 1 | Write the interrupt level |
| lvl_in | input | 5 | New interrupt level |
| cc | output | 4 | Condition code N Z V C |
| tir | output | 8 | Trap code [7:5] and interrupt level [4:0] |

## Verification
Add, subtract and compare are swept over every pair of byte operands, with unrelated data in the upper bytes. This separates correct truncation at the selected width from leaks from the higher bits. It also exercises every signed and unsigned boundary, including the 0x7F/0x80 edges where V and C diverge. Word and longword use the extreme values crossed with each other plus a long pseudo-random run. Move/test varies `old_c` and the high longword to tell carry preservation and quad zero detection apart from plain longword behaviour. The register sequence then drives simultaneous strobes to confirm the post priority and that the interrupt level survives every trap action.

// File: rtl/ccode_unit.sv
module ccode_unit #(
  parameter int DATA_W     = 32,
  parameter int LVL_W      = 5,
  parameter int TRAP_W     = 3,
  parameter int OVF_EN_BIT = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                op,
  input  logic [1:0]                size,
  input  logic [DATA_W-1:0]         src1,
  input  logic [DATA_W-1:0]         src2,
  input  logic [DATA_W-1:0]         res_lo,
  input  logic [DATA_W-1:0]         res_hi,
  input  logic                      old_c,
  input  logic [7:0]                psw,
  input  logic                      upd,
  input  logic                      clr_traps,
  input  logic                      post_trap,
  input  logic [TRAP_W-1:0]         trap_code,
  input  logic                      lvl_we,
  input  logic [LVL_W-1:0]          lvl_in,
  output logic [3:0]                cc,
  output logic [LVL_W+TRAP_W-1:0]   tir
);

  localparam int REG_W = LVL_W + TRAP_W;
  localparam logic [TRAP_W-1:0] CODE_INTOV = TRAP_W'(1);

  logic [DATA_W-1:0] msk, smsk, a, b, r;
  logic              is_quad, n, z, v, c;
  logic              add_v, sub_v, add_c, sub_c, cmp_n;

  always_comb begin
    case (size)
      2'd0:    msk = DATA_W'(8'hFF);
      2'd1:    msk = DATA_W'(16'hFFFF);
      default: msk = '1;
    endcase
  end

  assign smsk = msk & ~(msk >> 1);
  assign a    = src1 & msk;
  assign b    = src2 & msk;
  assign r    = res_lo & msk;

  assign add_v = |((~(a ^ b)) & (a ^ r) & smsk);
  assign sub_v = |((a ^ b) & (~a ^ r) & smsk);
  assign add_c = r < b;
  assign sub_c = b < a;
  assign cmp_n = (a ^ smsk) < (b ^ smsk);
  assign is_quad = (op == 2'd3) && (size == 2'd3);

  always_comb begin
    n = |(r & smsk);
    z = 1'b0;
    v = 1'b0;
    c = 1'b0;
    case (op)
      2'd0: begin
        z = !n && (r == '0);
        v = add_v;
        c = add_c;
      end
      2'd1: begin
        z = !n && (r == '0);
        v = sub_v;
        c = sub_c;
      end
      2'd2: begin
        n = cmp_n;
        z = !cmp_n && (a == b);
        c = a < b;
      end
      default: begin
        if (is_quad) begin
          n = res_hi[DATA_W-1];
          z = !n && ((res_lo | res_hi) == '0);
        end else begin
          z = !n && (r == '0);
        end
        c = old_c;
      end
    endcase
  end

  assign cc = {n, z, v, c};

  logic [REG_W-1:0] tir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tir_q <= '0;
    end else begin
      if (lvl_we)
        tir_q[LVL_W-1:0] <= lvl_in;
      if (upd && v && psw[OVF_EN_BIT])
        tir_q[REG_W-1:LVL_W] <= CODE_INTOV;
      else if (post_trap)
        tir_q[REG_W-1:LVL_W] <= trap_code;
      else if (clr_traps)
        tir_q[REG_W-1:LVL_W] <= '0;
    end
  end

  assign tir = tir_q;

endmodule

// File: rtl/ccode_unit_chk.sv
module ccode_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  op,
  input logic [1:0]  size,
  input logic [31:0] src1,
  input logic [31:0] src2,
  input logic [31:0] res_lo,
  input logic [31:0] res_hi,
  input logic        old_c,
  input logic [7:0]  psw,
  input logic        upd,
  input logic        clr_traps,
  input logic        post_trap,
  input logic [2:0]  trap_code,
  input logic        lvl_we,
  input logic [4:0]  lvl_in,
  input logic [3:0]  cc,
  input logic [7:0]  tir
);

  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cc[3] && cc[2])); // R2

  AST_CMP_NO_V: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd2) |-> !cc[1]); // R5

  AST_MOVE_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd3) |-> (!cc[1] && cc[0] == old_c)); // R6

  AST_OVF_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
    (live && upd && cc[1] && psw[5]) |=> (tir[7:5] == 3'd1)); // R8

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !lvl_we) |=> (tir[4:0] == $past(tir[4:0]))); // R9

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (live && clr_traps && !post_trap && !(upd && cc[1] && psw[5])) |=> (tir[7:5] == 3'd0)); // R10

  AST_POST_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (live && post_trap && !(upd && cc[1] && psw[5])) |=> (tir[7:5] == $past(trap_code))); // R11

endmodule

bind ccode_unit ccode_unit_chk chk_i (.*);

// File: tb/ccode_unit_tb_top.sv
`timescale 1ns/1ps
module ccode_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op = '0, size = '0;
  logic [31:0] src1 = '0, src2 = '0, res_lo = '0, res_hi = '0;
  logic        old_c = 1'b0;
  logic [7:0]  psw = '0;
  logic        upd = 1'b0, clr_traps = 1'b0, post_trap = 1'b0, lvl_we = 1'b0;
  logic [2:0]  trap_code = '0;
  logic [4:0]  lvl_in = '0;
  logic [3:0]  cc;
  logic [7:0]  tir;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ccode_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op(op), .size(size), .src1(src1), .src2(src2),
    .res_lo(res_lo), .res_hi(res_hi), .old_c(old_c), .psw(psw), .upd(upd),
    .clr_traps(clr_traps), .post_trap(post_trap), .trap_code(trap_code),
    .lvl_we(lvl_we), .lvl_in(lvl_in), .cc(cc), .tir(tir)
  );

  function automatic logic [3:0] exp_cc(int o, int sz, logic [31:0] s1, logic [31:0] s2,
                                        logic [31:0] rl, logic [31:0] rh, logic oc);
    longint w, m, half, av, bv, rv, sa, sb, t;
    logic n, z, v, c;
    w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m    = (64'sd1 <<< w) - 1;
    half = 64'sd1 <<< (w - 1);
    av   = longint'({32'b0, s1}) & m;
    bv   = longint'({32'b0, s2}) & m;
    sa   = (av >= half) ? av - (m + 1) : av;
    sb   = (bv >= half) ? bv - (m + 1) : bv;
    v = 1'b0; c = 1'b0;
    case (o)
      0: begin
        t = av + bv; rv = t & m;
        n = rv >= half; z = rv == 0;
        v = (sa + sb > half - 1) || (sa + sb < -half);
        c = t > m;
      end
      1: begin
        rv = (bv - av) & m;
        n = rv >= half; z = rv == 0;
        v = (sb - sa > half - 1) || (sb - sa < -half);
        c = bv < av;
      end
      2: begin
        n = sa < sb; z = av == bv; c = av < bv;
      end
      default: begin
        if (sz == 3) begin
          n = rh[31]; z = (rl == 0) && (rh == 0);
        end else begin
          rv = longint'({32'b0, rl}) & m;
          n = rv >= half; z = rv == 0;
        end
        c = oc;
      end
    endcase
    return {n, z, v, c};
  endfunction

  task automatic check_cc(int o, int sz, logic [31:0] s1, logic [31:0] s2,
                          logic [31:0] rh, logic oc, string req);
    logic [3:0] e;
    op = 2'(o); size = 2'(sz); src1 = s1; src2 = s2; res_hi = rh; old_c = oc;
    res_lo = (o == 0) ? s1 + s2 : (o == 1) ? s2 - s1 : s1;
    #1;
    e = exp_cc(o, sz, s1, s2, res_lo, rh, oc);
    checks++;
    if (cc !== e) begin
      errors++;
      $display("FAIL %s op=%0d size=%0d s1=%h s2=%h rh=%h: cc actual %b expected %b",
               req, o, sz, s1, s2, rh, cc, e);
    end
  endtask

  task automatic check_tir(logic [7:0] e, string req);
    checks++;
    if (tir !== e) begin
      errors++;
      $display("FAIL %s: tir actual %h expected %h", req, tir, e);
    end
  endtask

  task automatic idle_inputs();
    upd = 0; clr_traps = 0; post_trap = 0; lvl_we = 0; trap_code = 0; lvl_in = 0;
  endtask

  task automatic set_byte_ovf();
    op = 2'd0; size = 2'd0; src1 = 32'h7F; src2 = 32'h01; res_lo = 32'h80;
  endtask

  task automatic set_no_ovf();
    op = 2'd0; size = 2'd0; src1 = 32'h01; src2 = 32'h02; res_lo = 32'h03;
  endtask

  initial begin
    #900_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] edges [8];
    logic [31:0] lfsr;
    edges = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'h7FFF, 32'h8000, 32'h7FFFFFFF, 32'hFFFFFFFF};
    lfsr = 32'hACE1_2468;

    @(negedge clk);
    check_tir(8'h00, "R12 reset");
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5: full byte sweep with junk in upper bytes
    for (int o = 0; o < 3; o++)
      for (int i = 0; i < 256; i++)
        for (int j = 0; j < 256; j++)
          check_cc(o, 0, {8'(j), 8'(i ^ j), 8'hA5, 8'(i)},
                         {8'(i), 8'hC3, 8'(j ^ 8'h3C), 8'(j)}, 32'h0, 1'b0,
                   o == 0 ? "R3 add" : o == 1 ? "R4 sub" : "R5 cmp");

    // R1 R7: word, long and size-3 arithmetic on edge values and pseudo-random data
    for (int o = 0; o < 3; o++)
      for (int sz = 1; sz < 4; sz++) begin
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            check_cc(o, sz, edges[i], edges[j], 32'h0, 1'b0, "R1 R7 edge");
        for (int k = 0; k < 1500; k++) begin
          logic [31:0] x;
          lfsr = lfsr * 32'd1664525 + 32'd1013904223; x = lfsr;
          lfsr = lfsr * 32'd1664525 + 32'd1013904223;
          check_cc(o, sz, x, lfsr, 32'h0, 1'b0, "R1 R3 R4 R5 random");
        end
      end

    // R6 R7: move/test at all sizes, varying old carry and high word
    for (int sz = 0; sz < 4; sz++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          check_cc(3, sz, edges[i], 32'h0, edges[j], 1'b0, "R6 R7 move");
          check_cc(3, sz, edges[i], 32'h0, edges[j], 1'b1, "R6 R7 move");
        end
      for (int k = 0; k < 1000; k++) begin
        logic [31:0] x;
        lfsr = lfsr * 32'd1664525 + 32'd1013904223; x = lfsr;
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        check_cc(3, sz, x & {32{k[0]}}, 32'h0, lfsr & {32{k[1]}}, k[2], "R6 R7 move random");
      end
    end

    // register sequence: drive after negedge, check at the next negedge
    idle_inputs(); psw = 8'h00;
    @(negedge clk); lvl_we = 1; lvl_in = 5'h15;
    @(negedge clk); check_tir(8'h15, "R9 level write");
    idle_inputs(); set_byte_ovf(); psw = 8'h20; upd = 1;
    @(negedge clk); check_tir(8'h35, "R8 overflow posts");
    idle_inputs(); clr_traps = 1;
    @(negedge clk); check_tir(8'h15, "R10 clear");
    idle_inputs(); set_byte_ovf(); psw = 8'h00; upd = 1;
    @(negedge clk); check_tir(8'h15, "R8 disabled");
    idle_inputs(); set_no_ovf(); psw = 8'h20; upd = 1;
    @(negedge clk); check_tir(8'h15, "R8 no overflow");
    idle_inputs(); post_trap = 1; trap_code = 3'd6;
    @(negedge clk); check_tir(8'hD5, "R11 post");
    idle_inputs(); set_byte_ovf(); psw = 8'h20; upd = 1; post_trap = 1; trap_code = 3'd7;
    @(negedge clk); check_tir(8'h35, "R10 overflow beats post");
    idle_inputs(); post_trap = 1; trap_code = 3'd4; clr_traps = 1;
    @(negedge clk); check_tir(8'h95, "R10 post beats clear");
    idle_inputs(); set_byte_ovf(); psw = 8'h20; upd = 1; lvl_we = 1; lvl_in = 5'h03;
    @(negedge clk); check_tir(8'h23, "R9 level with overflow");
    idle_inputs(); set_no_ovf();
    @(negedge clk); check_tir(8'h23, "R9 idle hold");
    rst_n = 0; #1;
    check_tir(8'h00, "R12 mid-run reset");
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule